// File: doc/BRIEF.md
# RTC Interrupt Flag and Enable Control

This block holds the interrupt side of a real-time clock's control and status registers. Three one-cycle event pulses arrive from the rest of the clock: periodic tick, alarm match and update-ended. Each pulse latches a sticky flag. A control register stores one enable per source plus a square-wave enable. When any latched flag has its enable set, the block pulls a shared active-low interrupt line. That output is modelled as an output-enable with a fixed low drive level, so an external pull-up can serve several devices on the same line.

Software reads the status register and then pulses the status-read strobe. The strobe clears every flag and releases the line. The block also keeps a valid-RAM indicator. A low power-sense input forces that bit to zero. A read strobe for the valid-RAM register sets it again once power-sense is high.

The reset is active-low and sampled on the clock. It clears only the enables, the square-wave enable and the flags. The other control bits are left as they were. While reset is low, the register port ignores all writes and read strobes.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: `irq_oe` is 1 exactly when reset is high and some flag is 1 while its enable is also 1. `irq_lvl` is always 0.
- R2: A 1 on an `evt` bit sets the matching flag on the next clock edge, whatever the enable value. Event bit 2 is periodic and maps to `stat_q[6]`. Bit 1 is alarm and maps to `stat_q[5]`. Bit 0 is update-ended and maps to `stat_q[4]`.
- R3: `stat_q[7]` is the OR over the three sources of flag AND enable. `stat_q[3:0]` always reads 0.
- R4: A `stat_rd` pulse clears every flag whose event is not present in that cycle, effective on the next edge, and so releases `irq_oe`.
- R5: An event that arrives in the same cycle as `stat_rd` leaves its flag at 1 after the clear.
- R6: A `ctl_wr` pulse loads `ctl_wdata` into the control register, shown on `ctl_q` from the next edge. Bits 6, 5 and 4 enable the periodic, alarm and update-ended sources. Bit 3 is the square-wave enable.
- R7: A clock edge with `rst_n` low clears `ctl_q[6:3]` and all flags. It leaves `ctl_q[7]` and `ctl_q[2:0]` unchanged.
- R8: While `rst_n` is low, `irq_oe` is 0 without waiting for a clock edge. Writes and read strobes have no effect during that time.
- R9: While `pwr_ok` is low, `vram_q` is 0 and the stored valid-RAM bit is cleared on each edge.
- R10: With `pwr_ok` high and reset high, a `vram_rd` pulse sets `vram_q` from the next edge. It then stays 1 while `pwr_ok` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| pwr_ok | input | 1 | Power-sense input, low forces valid-RAM to 0 |
| evt | input | 3 | Event pulses: 2 periodic, 1 alarm, 0 update-ended |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register contents |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat_q | output | 8 | Status register contents |
| vram_rd | input | 1 | Valid-RAM register read strobe |
| vram_q | output | 1 | Valid-RAM bit |
| irq_oe | output | 1 | Interrupt line drive enable |
| irq_lvl | output | 1 | Level driven onto the interrupt line (always 0) |

## Verification
The bench builds the block with its default three sources and an 8-bit register width. At that size the full cross product of 8 enable patterns and 8 event patterns can be swept. Each pair's status byte and interrupt enable are predicted in the bench with a plain AND/OR. Every clear-plus-re-arrival combination is reached as well, by offsetting the event pattern during each read. Separate sequences cover the partial reset, the writes and reads ignored under reset, and the power-sense interplay with the valid-RAM bit.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int NSRC      = 3;
    localparam int REG_W     = 8;
    localparam int FLAG_BASE = 4;
    localparam int IRQF_BIT  = 7;

    // control register layout, MSB first; source order matches flag order
    typedef struct packed {
        logic            keep_hi;
        logic [NSRC-1:0] ien;
        logic            sqw_en;
        logic [2:0]      keep_lo;
    } ctrl_t;

    function automatic logic irq_summary(logic [NSRC-1:0] fl, logic [NSRC-1:0] en);
        return |(fl & en);
    endfunction

    function automatic logic [REG_W-1:0] pack_status(logic [NSRC-1:0] fl,
                                                     logic [NSRC-1:0] en);
        logic [REG_W-1:0] r;
        r = '0;
        r[IRQF_BIT] = irq_summary(fl, en);
        r[FLAG_BASE +: NSRC] = fl;
        return r;
    endfunction

endpackage

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;   // set beats clear: no lost event (R5)
        else if (clr_i)
            flag_o <= 1'b0;
    end

    a_r2_flag_set: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    a_r4_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_i,
    input  ctrl_t wdata_i,
    output ctrl_t q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o.ien    <= '0;
            q_o.sqw_en <= 1'b0;
        end else if (wr_i) begin
            q_o <= wdata_i;
        end
    end

    a_r6_write_load: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (q_o == $past(wdata_i)));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && !$past(rst)) |=> $stable(q_o));

endmodule

// File: rtl/rtc_vram_bit.sv
module rtc_vram_bit (
    input  logic clk,
    input  logic pwr_ok_i,
    input  logic acc_i,
    input  logic rd_i,
    output logic vld_o
);

    logic vld_r;

    always_ff @(posedge clk) begin
        if (!pwr_ok_i)
            vld_r <= 1'b0;
        else if (rd_i && acc_i)
            vld_r <= 1'b1;
    end

    assign vld_o = vld_r & pwr_ok_i;

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_ok,
    input  logic [NSRC-1:0]     evt,
    input  logic                ctl_wr,
    input  logic [REG_W-1:0]    ctl_wdata,
    output logic [REG_W-1:0]    ctl_q,
    input  logic                stat_rd,
    output logic [REG_W-1:0]    stat_q,
    input  logic                vram_rd,
    output logic                vram_q,
    output logic                irq_oe,
    output logic                irq_lvl
);

    logic            rst;
    logic            acc_ok;
    logic [NSRC-1:0] flags;
    ctrl_t           ctrl;

    assign rst    = ~rst_n;
    assign acc_ok = rst_n;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        rtc_flag_cell u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (evt[i]),
            .clr_i  (stat_rd & acc_ok),
            .flag_o (flags[i])
        );
    end

    rtc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (ctl_wr & acc_ok),
        .wdata_i (ctrl_t'(ctl_wdata)),
        .q_o     (ctrl)
    );

    rtc_vram_bit u_vram (
        .clk      (clk),
        .pwr_ok_i (pwr_ok),
        .acc_i    (acc_ok),
        .rd_i     (vram_rd),
        .vld_o    (vram_q)
    );

    assign ctl_q   = REG_W'(ctrl);
    assign stat_q  = pack_status(flags, ctrl.ien);
    assign irq_oe  = irq_summary(flags, ctrl.ien) & rst_n;
    assign irq_lvl = 1'b0;

    a_r1_line_matches_regs: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe == |(stat_q[FLAG_BASE +: NSRC] & ctl_q[FLAG_BASE +: NSRC]));

    a_r4_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && evt == '0) |=> !irq_oe);

    a_r9_power_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> !vram_q);

    a_r10_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && $past(vram_rd && pwr_ok && rst_n)) |-> vram_q);

endmodule

// File: tb/sim_rtc_irq_ctrl.sv
module sim_rtc_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n, pwr_ok, ctl_wr, stat_rd, vram_rd;
    logic [2:0] evt;
    logic [7:0] ctl_wdata, ctl_q, stat_q;
    logic       vram_q, irq_oe, irq_lvl;
    int         checks = 0, failures = 0;

    always #5 clk = ~clk;

    rtc_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .evt(evt),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .stat_rd(stat_rd), .stat_q(stat_q), .vram_rd(vram_rd),
        .vram_q(vram_q), .irq_oe(irq_oe), .irq_lvl(irq_lvl)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] wd;
        logic [2:0] ra;
        logic       irqf;
        rst_n = 0; pwr_ok = 0; evt = 0; ctl_wr = 0; ctl_wdata = 0;
        stat_rd = 0; vram_rd = 0;
        repeat (3) tick();
        chk("R7 reset status", stat_q, 8'h00);
        chk("R7 reset enables", {4'h0, ctl_q[6:3]}, 8'h00);
        chk("R8 reset line", {7'h0, irq_oe}, 8'h00);
        chk("R9 vram low", {7'h0, vram_q}, 8'h00);
        chk("R1 drive level", {7'h0, irq_lvl}, 8'h00);

        rst_n = 1;
        ctl_wr = 1; ctl_wdata = 8'h81; tick(); ctl_wr = 0;
        chk("R6 write", ctl_q, 8'h81);

        for (int en = 0; en < 8; en++) begin
            for (int ev = 0; ev < 8; ev++) begin
                wd = {1'b1, 3'(en), 1'(en[0] ^ en[1]), 3'b010};
                ctl_wr = 1; ctl_wdata = wd; tick(); ctl_wr = 0;
                chk("R6 sweep write", ctl_q, wd);
                stat_rd = 1; tick(); stat_rd = 0;
                chk("R4 cleared", stat_q, 8'h00);
                evt = 3'(ev); tick(); evt = 0;
                irqf = |(3'(ev) & 3'(en));
                chk("R2 R3 status", stat_q, {irqf, 3'(ev), 4'h0});
                chk("R1 line", {7'h0, irq_oe}, {7'h0, irqf});
                ra = 3'(ev + 1);
                stat_rd = 1; evt = ra; tick(); stat_rd = 0; evt = 0;
                chk("R5 re-arrival", {5'h0, stat_q[6:4]}, {5'h0, ra});
            end
        end

        // read releases the line
        ctl_wr = 1; ctl_wdata = 8'hF0; tick(); ctl_wr = 0;
        stat_rd = 1; tick(); stat_rd = 0;
        evt = 3'b010; tick(); evt = 0;
        chk("R1 alarm line", {7'h0, irq_oe}, 8'h01);
        stat_rd = 1; tick(); stat_rd = 0;
        chk("R4 release", {7'h0, irq_oe}, 8'h00);

        // partial reset
        ctl_wr = 1; ctl_wdata = 8'hFF; tick(); ctl_wr = 0;
        evt = 3'b111; tick(); evt = 0;
        chk("R1 all set", {7'h0, irq_oe}, 8'h01);
        rst_n = 0; #1;
        chk("R8 immediate release", {7'h0, irq_oe}, 8'h00);
        tick();
        chk("R7 partial clear", ctl_q, 8'h87);
        chk("R7 flags clear", stat_q, 8'h00);
        ctl_wr = 1; ctl_wdata = 8'h00; evt = 3'b111; tick();
        ctl_wr = 0; evt = 0;
        chk("R8 write ignored", ctl_q, 8'h87);
        chk("R7 events ignored", stat_q, 8'h00);
        pwr_ok = 1; vram_rd = 1; tick(); vram_rd = 0;
        chk("R8 vram read ignored", {7'h0, vram_q}, 8'h00);
        rst_n = 1; tick();
        chk("R7 retained", ctl_q, 8'h87);

        vram_rd = 1; tick(); vram_rd = 0;
        chk("R10 set", {7'h0, vram_q}, 8'h01);
        tick();
        chk("R10 hold", {7'h0, vram_q}, 8'h01);
        pwr_ok = 0; #1;
        chk("R9 forced", {7'h0, vram_q}, 8'h00);
        tick(); pwr_ok = 1; #1;
        chk("R9 stored cleared", {7'h0, vram_q}, 8'h00);
        vram_rd = 1; tick(); vram_rd = 0;
        chk("R10 set again", {7'h0, vram_q}, 8'h01);

        finish_run();
    end

endmodule